// File: doc/BRIEF.md
# Integer Issue Port Selector

This block chooses which ready micro-ops leave the scheduler in a cycle and where each one goes. It looks at a window of six candidates, oldest first, and places them on four integer ALU ports and two address-generation ports. Each port has its own abilities. One ALU holds the multiplier and a branch unit. A second ALU holds the divider. A third ALU holds the second branch unit. The fourth ALU does simple operations only. A micro-op with a memory operand needs an ALU port and an address port in the same cycle. It is granted both or neither.

Each candidate carries a valid bit, a class tag, a predicted-taken bit, a memory bit, a store bit and a thread ID. The block registers its decision and presents it on the next clock edge. That decision is a grant mask, the ALU port and address port of each granted candidate, and a busy strobe for every port. A candidate that does not fit is passed over, and younger candidates can still fill the ports that are left.

Top module: `int_issue_sel`

## Requirements
- R1: A synchronous active-high reset clears `grant`, `alu_sel`, `agu_sel`, `alu_vld` and `agu_vld` to zero.
- R2: No more than four candidates are granted per cycle. Each granted candidate is on a different ALU, and `alu_vld` has one bit set for each granted candidate.
- R3: A simple micro-op (class 0) may use any ALU. The preferred order is ALU2, then ALU1, then ALU3, then ALU0.
- R4: A multiply micro-op (class 1) may use only ALU0. A divide micro-op (class 2) may use only ALU1.
- R5: A branch micro-op (class 3) may use only ALU3 or ALU0, with ALU3 tried first. No more than two branches are granted per cycle.
- R6: Two branches are granted together only when neither one is predicted taken. Once a predicted-taken branch is granted, no other branch is granted that cycle. A predicted-taken branch is also refused if a branch has already been granted.
- R7: The thread ID does not affect any grant or port choice. Two branches from the same thread may pair, and so may two branches from different threads.
- R8: A memory micro-op is granted only if an ALU and an address port are both free. It then takes AGU0 first, otherwise AGU1. The `agu_vld` popcount equals the number of granted memory micro-ops.
- R9: At most one store (store flag = 1) is granted per cycle. Two loads, or one load and one store, may issue together.
- R10: Candidates are served in age order, with index 0 the oldest. A candidate that cannot be placed is skipped, and younger ones still compete for the ports that remain.
- R11: Outputs reflect the inputs of the previous cycle. An invalid candidate is never granted, whatever its other flags. Per-candidate fields are packed with candidate i at `alu_sel[2i+1:2i]` and `agu_sel[i]`, and they read zero when not granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | NCAND | Candidate ready bits, index 0 oldest |
| cand_cls | input | 2*NCAND | Class per candidate: 0 simple, 1 multiply, 2 divide, 3 branch |
| cand_taken | input | NCAND | Branch predicted taken |
| cand_mem | input | NCAND | Candidate has a memory operand |
| cand_store | input | NCAND | Memory access is a store (0 = load) |
| cand_tid | input | NCAND*TIDW | Thread ID per candidate |
| grant | output | NCAND | Registered grant mask |
| alu_sel | output | 2*NCAND | ALU port index per candidate |
| agu_sel | output | NCAND | Address port index per candidate |
| alu_vld | output | 4 | ALU port busy strobes |
| agu_vld | output | 2 | Address port busy strobes |

## Verification
The hardest case to reach from the ports is a window where several limits collide at once. In that window a memory multiply claims ALU0 and an address port, a divide-store claims the other address port, and a later load finds an ALU free but no address port. A trailing branch then finds its second branch ALU taken by the multiply. The stimulus table has rows built for exactly that pile-up. Other rows put a taken branch in front of and behind a not-taken one, and place two stores back to back. A reference model with its own port-search formulation predicts every port field, and hand-derived grant masks check the age-order skipping.

// File: rtl/iis_pkg.sv
package iis_pkg;
  localparam int NALU = 4;
  localparam int NAGU = 2;

  typedef enum logic [1:0] {CLS_SIMPLE = 2'd0, CLS_MUL = 2'd1, CLS_DIV = 2'd2, CLS_BR = 2'd3} cls_e;

  // resources consumed so far by older candidates
  typedef struct packed {
    logic [NALU-1:0] alu_busy;
    logic [NAGU-1:0] agu_busy;
    logic            st_used;
    logic [1:0]      br_cnt;
    logic            br_tkn;
  } res_t;

  // ALUs that can execute a class
  function automatic logic [NALU-1:0] cls_alus(cls_e c);
    case (c)
      CLS_MUL: return 4'b0001;
      CLS_DIV: return 4'b0010;
      CLS_BR:  return 4'b1001;
      default: return 4'b1111;
    endcase
  endfunction

  // preference order 2,1,3,0 keeps specialised ports free
  function automatic logic [1:0] pick_alu(logic [NALU-1:0] m);
    if (m[2])      return 2'd2;
    else if (m[1]) return 2'd1;
    else if (m[3]) return 2'd3;
    else           return 2'd0;
  endfunction

  function automatic logic branch_fits(res_t r, logic tk);
    return (r.br_cnt == 2'd0) || (r.br_cnt == 2'd1 && !r.br_tkn && !tk);
  endfunction
endpackage

// File: rtl/iis_stage.sv
module iis_stage
  import iis_pkg::*;
(
  input  res_t       res_in,
  input  logic       vld,
  input  cls_e       cls,
  input  logic       tk,
  input  logic       mem,
  input  logic       st,
  output res_t       res_out,
  output logic       gnt,
  output logic [1:0] alu_idx,
  output logic       agu_idx
);
  logic [NALU-1:0] free_ok;
  logic            br_ok, mem_ok;
  logic [1:0]      alu_pick;
  logic            agu_pick;

  always_comb begin
    free_ok  = cls_alus(cls) & ~res_in.alu_busy;
    br_ok    = (cls != CLS_BR) || branch_fits(res_in, tk);
    mem_ok   = !mem || ((res_in.agu_busy != 2'b11) && !(st && res_in.st_used));
    gnt      = vld && (|free_ok) && br_ok && mem_ok;
    alu_pick = pick_alu(free_ok);
    agu_pick = res_in.agu_busy[0];
    alu_idx  = gnt ? alu_pick : 2'd0;
    agu_idx  = (gnt && mem) ? agu_pick : 1'b0;
    res_out  = res_in;
    if (gnt) begin
      res_out.alu_busy[alu_pick] = 1'b1;
      if (mem) begin
        res_out.agu_busy[agu_pick] = 1'b1;
        if (st) res_out.st_used = 1'b1;
      end
      if (cls == CLS_BR) begin
        res_out.br_cnt = res_in.br_cnt + 2'd1;
        res_out.br_tkn = res_in.br_tkn | tk;
      end
    end
  end
endmodule

// File: rtl/iis_out_reg.sv
module iis_out_reg #(
  parameter int NCAND = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NCAND-1:0]   grant_d,
  input  logic [2*NCAND-1:0] alu_sel_d,
  input  logic [NCAND-1:0]   agu_sel_d,
  input  logic [3:0]         alu_vld_d,
  input  logic [1:0]         agu_vld_d,
  output logic [NCAND-1:0]   grant_q,
  output logic [2*NCAND-1:0] alu_sel_q,
  output logic [NCAND-1:0]   agu_sel_q,
  output logic [3:0]         alu_vld_q,
  output logic [1:0]         agu_vld_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q   <= '0;
      alu_sel_q <= '0;
      agu_sel_q <= '0;
      alu_vld_q <= '0;
      agu_vld_q <= '0;
    end else begin
      grant_q   <= grant_d;
      alu_sel_q <= alu_sel_d;
      agu_sel_q <= agu_sel_d;
      alu_vld_q <= alu_vld_d;
      agu_vld_q <= agu_vld_d;
    end
  end
endmodule

// File: rtl/int_issue_sel.sv
module int_issue_sel
  import iis_pkg::*;
#(
  parameter int NCAND = 6,
  parameter int TIDW  = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCAND-1:0]      cand_valid,
  input  logic [2*NCAND-1:0]    cand_cls,
  input  logic [NCAND-1:0]      cand_taken,
  input  logic [NCAND-1:0]      cand_mem,
  input  logic [NCAND-1:0]      cand_store,
  input  logic [NCAND*TIDW-1:0] cand_tid,
  output logic [NCAND-1:0]      grant,
  output logic [2*NCAND-1:0]    alu_sel,
  output logic [NCAND-1:0]      agu_sel,
  output logic [NALU-1:0]       alu_vld,
  output logic [NAGU-1:0]       agu_vld
);
  res_t               res_chain [NCAND+1];
  logic [NCAND-1:0]   grant_d;
  logic [2*NCAND-1:0] alu_sel_d;
  logic [NCAND-1:0]   agu_sel_d;
  logic               unused_tid;

  // thread ID does not steer pairing or placement
  assign unused_tid   = ^cand_tid;
  assign res_chain[0] = '0;

  for (genvar i = 0; i < NCAND; i++) begin : g_slot
    iis_stage u_stage (
      .res_in  (res_chain[i]),
      .vld     (cand_valid[i]),
      .cls     (cls_e'(cand_cls[2*i +: 2])),
      .tk      (cand_taken[i]),
      .mem     (cand_mem[i]),
      .st      (cand_store[i]),
      .res_out (res_chain[i+1]),
      .gnt     (grant_d[i]),
      .alu_idx (alu_sel_d[2*i +: 2]),
      .agu_idx (agu_sel_d[i])
    );
  end

  iis_out_reg #(.NCAND(NCAND)) u_out (
    .clk       (clk),
    .rst       (rst),
    .grant_d   (grant_d),
    .alu_sel_d (alu_sel_d),
    .agu_sel_d (agu_sel_d),
    .alu_vld_d (res_chain[NCAND].alu_busy),
    .agu_vld_d (res_chain[NCAND].agu_busy),
    .grant_q   (grant),
    .alu_sel_q (alu_sel),
    .agu_sel_q (agu_sel),
    .alu_vld_q (alu_vld),
    .agu_vld_q (agu_vld)
  );
endmodule

// File: rtl/iis_chk.sv
module iis_chk #(
  parameter int NCAND = 6,
  parameter int TIDW  = 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NCAND-1:0]      cand_valid,
  input logic [2*NCAND-1:0]    cand_cls,
  input logic [NCAND-1:0]      cand_taken,
  input logic [NCAND-1:0]      cand_mem,
  input logic [NCAND-1:0]      cand_store,
  input logic [NCAND*TIDW-1:0] cand_tid,
  input logic [NCAND-1:0]      grant,
  input logic [2*NCAND-1:0]    alu_sel,
  input logic [NCAND-1:0]      agu_sel,
  input logic [3:0]            alu_vld,
  input logic [1:0]            agu_vld
);
  logic [NCAND-1:0] is_br, is_tk_br, is_mem, is_st;
  logic             unused_chk;

  assign unused_chk = ^{cand_tid, agu_sel};

  for (genvar i = 0; i < NCAND; i++) begin : g_cls
    assign is_br[i]    = cand_valid[i] && cand_cls[2*i +: 2] == 2'd3;
    assign is_tk_br[i] = is_br[i] && cand_taken[i];
    assign is_mem[i]   = cand_valid[i] && cand_mem[i];
    assign is_st[i]    = is_mem[i] && cand_store[i];

    // R4
    mul_port_chk: assert property (@(posedge clk) disable iff (rst)
      (cand_valid[i] && cand_cls[2*i +: 2] == 2'd1) |=> (!grant[i] || alu_sel[2*i +: 2] == 2'd0));
    // R4
    div_port_chk: assert property (@(posedge clk) disable iff (rst)
      (cand_valid[i] && cand_cls[2*i +: 2] == 2'd2) |=> (!grant[i] || alu_sel[2*i +: 2] == 2'd1));
    // R5
    br_port_chk: assert property (@(posedge clk) disable iff (rst)
      is_br[i] |=> (!grant[i] || alu_sel[2*i +: 2] == 2'd0 || alu_sel[2*i +: 2] == 2'd3));
  end

  // R2
  alu_count_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(alu_vld) == $countones(grant));
  // R5
  br_limit_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(grant & $past(is_br)) <= 2);
  // R6
  taken_alone_chk: assert property (@(posedge clk) disable iff (rst)
    ((grant & $past(is_tk_br)) != '0) |-> ($countones(grant & $past(is_br)) == 1));
  // R8
  agu_count_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(agu_vld) == $countones(grant & $past(is_mem)));
  // R9
  store_limit_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(grant & $past(is_st)) <= 1);
  // R11
  no_invalid_chk: assert property (@(posedge clk) disable iff (rst)
    (grant & ~$past(cand_valid)) == '0);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (grant == '0 && alu_vld == '0 && agu_vld == '0));
endmodule

bind int_issue_sel iis_chk #(.NCAND(NCAND), .TIDW(TIDW)) u_chk (.*);

// File: tb/tb_int_issue_sel.sv
module tb_int_issue_sel;
  localparam int N  = 6;
  localparam int NV = 12;
  // candidate code {valid, cls[1:0], taken, mem, store, tid}
  localparam logic [6:0] S = 7'b1000000, MU = 7'b1010000, DV = 7'b1100000;
  localparam logic [6:0] BN = 7'b1110000, BT = 7'b1111000, BN1 = 7'b1110001;
  localparam logic [6:0] LD = 7'b1000100, ST = 7'b1000110, Z = 7'b0000000;
  localparam logic [6:0] MLD = 7'b1010100, DST = 7'b1100110;

  localparam logic [6:0] STIM [NV][N] = '{
    '{S, S, S, S, S, S},
    '{MU, MU, DV, DV, S, S},
    '{BN, BN, BN, S, S, S},
    '{BT, BN, S, S, S, S},
    '{BN, BT, BN, Z, Z, Z},
    '{LD, LD, LD, ST, Z, Z},
    '{ST, ST, LD, S, Z, Z},
    '{BN, BN1, Z, Z, Z, Z},
    '{Z, Z, Z, Z, Z, Z},
    '{MLD, DST, LD, S, BN, BN},
    '{7'b0111110, 7'b1000001, 7'b0010000, Z, Z, Z},
    '{BN1, BN1, S, Z, Z, Z}
  };
  localparam logic [N-1:0] EXPG [NV] = '{
    6'b001111, 6'b110101, 6'b011011, 6'b011101, 6'b000101, 6'b000011,
    6'b001101, 6'b000011, 6'b000000, 6'b011011, 6'b000010, 6'b000111
  };
  localparam string VREQ [NV] = '{
    "R2/R3", "R4/R10", "R5", "R6", "R6", "R8/R9",
    "R9/R10", "R7", "R11", "R8/R5", "R11/R7", "R7"
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   cand_valid = '0, cand_taken = '0, cand_mem = '0, cand_store = '0, cand_tid = '0;
  logic [2*N-1:0] cand_cls = '0;
  logic [N-1:0]   grant, agu_sel;
  logic [2*N-1:0] alu_sel;
  logic [3:0]     alu_vld;
  logic [1:0]     agu_vld;
  int             n_run = 0, n_fail = 0;
  logic [6:0]     cur [N];

  always #2 clk = ~clk;

  int_issue_sel #(.NCAND(N), .TIDW(1)) dut (
    .clk(clk), .rst(rst), .cand_valid(cand_valid), .cand_cls(cand_cls),
    .cand_taken(cand_taken), .cand_mem(cand_mem), .cand_store(cand_store),
    .cand_tid(cand_tid), .grant(grant), .alu_sel(alu_sel), .agu_sel(agu_sel),
    .alu_vld(alu_vld), .agu_vld(agu_vld)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] c [N]);
    for (int i = 0; i < N; i++) begin
      cur[i]           = c[i];
      cand_valid[i]    = c[i][6];
      cand_cls[2*i+:2] = c[i][5:4];
      cand_taken[i]    = c[i][3];
      cand_mem[i]      = c[i][2];
      cand_store[i]    = c[i][1];
      cand_tid[i]      = c[i][0];
    end
  endtask

  // reference: for each candidate, walk ports in preference order
  task automatic model(output logic [N-1:0] g, output logic [2*N-1:0] as,
                       output logic [N-1:0] gs, output logic [3:0] av, output logic [1:0] gv);
    int pref [4] = '{2, 1, 3, 0};
    int nbr = 0, nst = 0;
    bit tkseen = 0;
    g = '0; as = '0; gs = '0; av = '0; gv = '0;
    for (int i = 0; i < N; i++) begin
      int cls = int'(cur[i][5:4]);
      int port = -1;
      int agu = -1;
      if (!cur[i][6]) continue;
      for (int k = 0; k < 4; k++) begin
        int p = pref[k];
        bit can = (cls == 0) || (cls == 1 && p == 0) || (cls == 2 && p == 1) || (cls == 3 && (p == 0 || p == 3));
        if (port < 0 && can && !av[p]) port = p;
      end
      if (port < 0) continue;
      if (cls == 3 && !(nbr == 0 || (nbr == 1 && !tkseen && !cur[i][3]))) continue;
      if (cur[i][2]) begin
        if (cur[i][1] && nst > 0) continue;
        if (!gv[0]) agu = 0; else if (!gv[1]) agu = 1; else continue;
        gv[agu] = 1'b1;
        gs[i]   = 1'(agu);
        if (cur[i][1]) nst++;
      end
      if (cls == 3) begin nbr++; tkseen = tkseen | cur[i][3]; end
      av[port]     = 1'b1;
      g[i]         = 1'b1;
      as[2*i +: 2] = 2'(port);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0] eg, egs;
    logic [2*N-1:0] eas;
    logic [3:0] eav;
    logic [1:0] egv;
    logic [6:0] zero6 [N] = '{Z, Z, Z, Z, Z, Z};
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(grant == '0 && alu_vld == '0 && agu_vld == '0 && alu_sel == '0 && agu_sel == '0,
          "R1", {grant, alu_vld, agu_vld}, 0);
    @(negedge clk) rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk) drive(STIM[v]);
      model(eg, eas, egs, eav, egv);
      @(posedge clk); #1;
      check(grant == EXPG[v], VREQ[v], grant, EXPG[v]);
      check(grant == eg && alu_sel == eas && agu_sel == egs, VREQ[v], {grant, alu_sel, agu_sel}, {eg, eas, egs});
      check(alu_vld == eav && agu_vld == egv, VREQ[v], {alu_vld, agu_vld}, {eav, egv});
    end

    // R11: one-cycle latency, previous decision replaced by empty window
    @(negedge clk) drive(STIM[0]);
    #1 check(grant == EXPG[NV-1], "R11", grant, EXPG[NV-1]);
    @(posedge clk); #1;
    check(grant == 6'b001111, "R11", grant, 6'b001111);
    @(negedge clk) drive(zero6);
    @(posedge clk); #1;
    check(grant == '0 && alu_vld == '0, "R11", {grant, alu_vld}, 0);

    // R1: reset mid-stream with a full window presented
    @(negedge clk) begin drive(STIM[9]); rst = 1'b1; end
    @(posedge clk); #1;
    check(grant == '0 && alu_vld == '0 && agu_vld == '0, "R1", {grant, alu_vld, agu_vld}, 0);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    check(grant == 6'b011011 && agu_vld == 2'b11, "R8", {grant, agu_vld}, {6'b011011, 2'b11});

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule